// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge stands between a memory-mapped requester and a downstream memory port. It exposes a 32 MB alias window in which every 32-bit word stands for exactly one bit of a smaller target region. The requester presents an offset into the alias window. The bridge turns it into a target byte address and a bit position. It then reaches the target through the downstream port.

An alias read fetches the containing unit of 1, 2 or 4 bytes and returns only the chosen bit, in bit 0. An alias write runs a read-modify-write. It fetches the unit, sets or clears the one bit according to bit 0 of the write data, and writes the full unit back. Downstream errors are passed back to the requester, and an error on the fetch cancels the write-back.

Only one transaction is in flight at a time. Arbitration, caching and atomicity against other masters are left to the surrounding system. A typical system places two instances: one with its window at 0x2200_0000 over a base of 0x2000_0000, and one with its window at 0x4200_0000 over a base of 0x4000_0000.

Top module: `bitband_bridge`

## Requirements
- R1: The target byte address is BASE_ADDR ORed with the 25-bit alias offset shifted right by 5.
- R2: The size code gives the access unit (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The downstream address is the target address rounded down to a multiple of that unit, and it is sent together with the same size code.
- R3: The bit position is offset bits [6:2], masked to 3, 4 or 5 bits for unit sizes of 1, 2 or 4 bytes. Lanes are little-endian and the unit is right-justified on both downstream data buses, so byte lane k is data bits [8k+7:8k].
- R4: A successful read responds with rsp_err=0 and the selected bit in rsp_rdata[0]. All other response bits are zero, and every write response returns zero data.
- R5: A write reads the unit, then writes back the same unit with only the selected bit changed: it is set when up_wdata[0] is 1 and cleared otherwise. Bits [31:1] of up_wdata have no effect.
- R6: If the downstream read reports an error, the response carries rsp_err=1 and no downstream write is issued.
- R7: If the downstream write-back reports an error, the response carries rsp_err=1.
- R8: up_ready goes low in the cycle after a request is accepted and stays low until the response has been given. A downstream request holds its address and direction until dn_ready is seen.
- R9: Size code 3 is illegal. It is answered with rsp_err=1 and no downstream access.
- R10: After reset, up_ready=1, dn_req=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge idle and accepting a request |
| up_we | input | 1 | 1 = alias write, 0 = alias read |
| up_size | input | 2 | Access size code |
| up_offset | input | 25 | Byte offset inside the alias window |
| up_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Read result, selected bit in bit 0 |
| dn_req | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_we | output | 1 | Downstream write |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Downstream aligned byte address |
| dn_wdata | output | 32 | Write-back unit, right-justified |
| dn_ack | input | 1 | Downstream completion strobe |
| dn_err | input | 1 | Downstream error, valid with dn_ack |
| dn_rdata | input | 32 | Downstream read unit, right-justified |

## Verification
The case that is hardest to reach from the ports is an alias write whose fetch fails. The read-error path and the write-back path part there, and a faulty bridge could still write a partly built unit. The bench makes its downstream memory model answer one chosen aligned address with an error. It then issues a write to that address and confirms three things: the response carries the error, no downstream write was accepted, and the stored bytes are unchanged. Stalling dn_ready over long random sequences also keeps a request waiting at the downstream side while the bridge must hold it stable.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
  parameter int          OFFS_W    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  output logic              up_ready,
  input  logic              up_we,
  input  logic [1:0]        up_size,
  input  logic [OFFS_W-1:0] up_offset,
  input  logic [31:0]       up_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              dn_req,
  input  logic              dn_ready,
  output logic              dn_we,
  output logic [1:0]        dn_size,
  output logic [31:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [31:0]       dn_rdata
);

  localparam int WORD_SHIFT = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_RESP
  } state_t;

  state_t      st;
  logic        op_wr, new_bit, err_q, rbit_q;
  logic [1:0]  size_q;
  logic [31:0] addr_q, unit_q;
  logic [4:0]  pos_q;

  logic        accept;
  logic [31:0] raw_tgt, lo_mask, unit_mask, sel_mask;
  logic [4:0]  pos_mask;

  assign accept  = up_req && up_ready;
  assign raw_tgt = BASE_ADDR | 32'(up_offset >> WORD_SHIFT);

  always_comb begin
    case (up_size)
      2'd0:    begin lo_mask = 32'd0; pos_mask = 5'd7;  end
      2'd1:    begin lo_mask = 32'd1; pos_mask = 5'd15; end
      default: begin lo_mask = 32'd3; pos_mask = 5'd31; end
    endcase
  end

  always_comb begin
    case (size_q)
      2'd0:    unit_mask = 32'h0000_00ff;
      2'd1:    unit_mask = 32'h0000_ffff;
      default: unit_mask = 32'hffff_ffff;
    endcase
  end

  assign sel_mask = 32'd1 << pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_wr   <= 1'b0;
      new_bit <= 1'b0;
      err_q   <= 1'b0;
      rbit_q  <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= 32'd0;
      unit_q  <= 32'd0;
      pos_q   <= 5'd0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_wr   <= up_we;
          new_bit <= up_wdata[0];
          size_q  <= up_size;
          addr_q  <= raw_tgt & ~lo_mask;
          pos_q   <= up_offset[6:2] & pos_mask;
          rbit_q  <= 1'b0;
          unit_q  <= 32'd0;
          if (up_size == 2'd3) begin
            err_q <= 1'b1;
            st    <= S_RESP;
          end else begin
            err_q <= 1'b0;
            st    <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (dn_ready) st <= S_RD_WAIT;
        S_RD_WAIT: if (dn_ack) begin
          if (dn_err) begin
            err_q <= 1'b1;
            st    <= S_RESP;
          end else if (op_wr) begin
            unit_q <= (dn_rdata & unit_mask & ~sel_mask) | (new_bit ? sel_mask : 32'd0);
            st     <= S_WR_REQ;
          end else begin
            rbit_q <= |(dn_rdata & sel_mask);
            st     <= S_RESP;
          end
        end
        S_WR_REQ: if (dn_ready) st <= S_WR_WAIT;
        S_WR_WAIT: if (dn_ack) begin
          err_q <= dn_err;
          st    <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign up_ready  = (st == S_IDLE);
  assign dn_req    = (st == S_RD_REQ) || (st == S_WR_REQ);
  assign dn_we     = (st == S_WR_REQ);
  assign dn_size   = size_q;
  assign dn_addr   = addr_q;
  assign dn_wdata  = unit_q;
  assign rsp_valid = (st == S_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = {31'd0, rbit_q};

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !up_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));

  assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> ((dn_addr & ((32'd1 << dn_size) - 32'd1)) == 32'd0));

  assert_onebit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

  assert_clean_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req && dn_we) |-> $past(dn_ack && !dn_err));

  assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && up_size == 2'd3) |=> (rsp_valid && rsp_err && !dn_req));

endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h2000_0000;

  logic        clk = 0, rst_n = 0;
  logic        up_req = 0, up_we = 0;
  logic [1:0]  up_size = 0;
  logic [24:0] up_offset = 0;
  logic [31:0] up_wdata = 0;
  logic        up_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        dn_req, dn_we, dn_ready;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ack = 0, dn_err = 0;
  logic [31:0] dn_rdata = 0;

  bitband_bridge #(.BASE_ADDR(BASE), .OFFS_W(25)) dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ready(up_ready), .up_we(up_we),
    .up_size(up_size), .up_offset(up_offset), .up_wdata(up_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_req(dn_req), .dn_ready(dn_ready), .dn_we(dn_we), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err),
    .dn_rdata(dn_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  int unsigned n_wr = 0, n_acc = 0;
  logic stall_en = 0;
  logic [31:0] err_rd_addr = 32'hffff_ffff, err_wr_addr = 32'hffff_ffff;

  logic [7:0] dmem [int unsigned];
  logic [7:0] rmem [int unsigned];

  function automatic logic [7:0] fill(input int unsigned a);
    return 8'(a * 37) ^ 8'h5c;
  endfunction

  function automatic logic [7:0] dget(input int unsigned a);
    return dmem.exists(a) ? dmem[a] : fill(a);
  endfunction

  function automatic logic [7:0] rget(input int unsigned a);
    return rmem.exists(a) ? rmem[a] : fill(a);
  endfunction

  assign dn_ready = !stall_en || (cyc[1:0] == 2'd3);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    dn_ack <= 1'b0;
    dn_err <= 1'b0;
    if (rst_n && dn_req && dn_ready) begin
      automatic int unsigned nb = 1 << dn_size;
      automatic logic [31:0] d = 32'd0;
      n_acc <= n_acc + 1;
      dn_ack <= 1'b1;
      if (dn_we) begin
        n_wr <= n_wr + 1;
        if (dn_addr == err_wr_addr) dn_err <= 1'b1;
        else for (int k = 0; k < nb; k++) dmem[dn_addr + k] = dn_wdata[8*k +: 8];
      end else begin
        if (dn_addr == err_rd_addr) dn_err <= 1'b1;
        for (int k = 0; k < nb; k++) d[8*k +: 8] = dget(dn_addr + k);
        dn_rdata <= d;
      end
    end
  end

  typedef struct { logic e; logic [31:0] d; string tag; } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected response: actual err=%0b data=%h expected none", rsp_err, rsp_rdata);
      end else begin
        automatic exp_t x = q.pop_front();
        if (rsp_err !== x.e || rsp_rdata !== x.d) begin
          fails++;
          $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                   x.tag, rsp_err, rsp_rdata, x.e, x.d);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [1:0] sz, input logic [24:0] off,
                    input logic [31:0] wd, input string tag);
    exp_t x;
    int unsigned nb, a, bp, ba;
    logic [7:0] b;
    x.tag = tag; x.e = 0; x.d = 0;
    if (sz == 2'd3) x.e = 1;
    else begin
      nb = 1 << sz;
      a  = (BASE | 32'(off >> 5)) & ~(nb - 1);
      bp = 32'(off >> 2) & (nb*8 - 1);
      ba = a + bp / 8;
      b  = rget(ba);
      if (a == err_rd_addr) x.e = 1;
      else if (!we) x.d = {31'd0, b[bp % 8]};
      else if (a == err_wr_addr) x.e = 1;
      else begin
        b[bp % 8] = wd[0];
        rmem[ba] = b;
      end
    end
    q.push_back(x);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_req = 1; up_we = we; up_size = sz; up_offset = off; up_wdata = wd;
    @(negedge clk);
    up_req = 0;
    chk(up_ready == 1'b0, "R8 busy after accept", {31'd0, up_ready}, 32'd0);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic mem_chk(input int unsigned a, input int unsigned nb, input string tag);
    for (int k = 0; k < nb; k++)
      chk(dget(a + k) === rget(a + k), tag, {24'd0, dget(a + k)}, {24'd0, rget(a + k)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned w0, a0;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(up_ready === 1 && dn_req === 0 && rsp_valid === 0, "R10 reset state",
        {29'd0, up_ready, dn_req, rsp_valid}, 32'h4);

    op(0, 2'd2, 25'(5 << 2), 0, "R1 R4 word read bit 5");
    op(0, 2'd0, 25'((32'h13 << 5) | (3 << 2)), 0, "R3 byte read");
    op(0, 2'd1, 25'((32'h13 << 5) | (6 << 2)), 0, "R2 R3 half read odd target");
    op(0, 2'd2, 25'h1ff_fffc, 0, "R1 top of window bit 31");

    op(1, 2'd2, 25'((32'h40 << 5) | (17 << 2)), 32'h1, "R5 word set");
    mem_chk(BASE + 32'h40, 4, "R5 word set memory");
    op(0, 2'd2, 25'((32'h40 << 5) | (17 << 2)), 0, "R5 readback set");
    op(1, 2'd0, 25'((32'h41 << 5) | (2 << 2)), 32'hffff_fffe, "R5 byte clear, upper wdata ignored");
    mem_chk(BASE + 32'h41, 1, "R5 byte clear memory");
    op(1, 2'd1, 25'((32'h57 << 5) | (15 << 2)), 32'h1, "R2 R5 half set odd target");
    mem_chk(BASE + 32'h56, 2, "R2 R5 half memory");

    err_rd_addr = BASE + 32'h80;
    w0 = n_wr;
    op(1, 2'd2, 25'((32'h82 << 5) | (9 << 2)), 32'h1, "R6 fetch error on write");
    chk(n_wr == w0, "R6 no write-back", n_wr, w0);
    mem_chk(BASE + 32'h80, 4, "R6 memory unchanged");
    op(0, 2'd0, 25'(32'h80 << 5), 0, "R6 read error");
    err_rd_addr = 32'hffff_ffff;

    err_wr_addr = BASE + 32'h90;
    op(1, 2'd2, 25'((32'h90 << 5) | (4 << 2)), 32'h0, "R7 write-back error");
    err_wr_addr = 32'hffff_ffff;

    a0 = n_acc;
    op(0, 2'd3, 25'h123, 0, "R9 illegal size");
    chk(n_acc == a0, "R9 no downstream access", n_acc, a0);

    stall_en = 1;
    lf = 32'hace1_2345;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op(lf[0], 2'(lf[3:2] % 3), 25'({lf[10:4], lf[17:13]}), {31'd0, lf[19]}, "R1 R3 R5 random stalled");
    end
    stall_en = 0;
    for (int k = 0; k < 16; k++)
      op(0, 2'd0, 25'(k << 2) | 25'(32'h41 << 5), 0, "R4 byte sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule